// File: doc/BRIEF.md
# Packed-Lane Integer ALU

This combinational arithmetic unit serves the execute stage of a small 16-bit processor. It takes two operand words and a 4-bit function code and returns one 16-bit result in the same cycle. Instruction decode picks the function code, and immediate forms are mapped onto these codes before the operands arrive.

The scalar functions are add, subtract, the three shifts, signed set-less-than, OR and AND. The packed functions split each operand into two unsigned byte lanes and work on each lane independently. They do multiply, divide, add and subtract, and no carry, borrow or product bit crosses the lane boundary between bits 7 and 8. Each lane result lands in its own byte of the output word. No flags are produced.

Top module: `alu16_lanes`

## Requirements
- R1: Code 0 returns the sum of A and B modulo 2^16.
- R2: Code 1 returns A minus B modulo 2^16.
- R3: Code 2 shifts A left by the amount in B[3:0] and fills with zeros; B[15:4] has no effect.
- R4: Code 3 shifts A right by B[3:0] and fills the vacated upper bits with zeros.
- R5: Code 4 shifts A right by B[3:0] and fills the vacated upper bits with copies of A[15].
- R6: Code 5 returns 0x0001 when A is less than B as signed two's complement numbers, else 0x0000.
- R7: Code 6 returns A OR B and code 7 returns A AND B, bitwise.
- R8: Code 8 multiplies A[15:8] by B[15:8] and A[7:0] by B[7:0] as unsigned bytes. The low 8 bits of each product go to result bits [15:8] and [7:0].
- R9: Code 9 places the unsigned quotient A[15:8]/B[15:8] in result bits [15:8] and A[7:0]/B[7:0] in bits [7:0], each rounded toward zero.
- R10: Under code 9, a lane whose divisor byte is zero yields 0xFF in that lane, and the other lane is unaffected.
- R11: Code 10 adds byte lanes modulo 256 each, with no carry from bit 7 into bit 8.
- R12: Code 11 subtracts byte lanes (A minus B) modulo 256 each, with no borrow from bit 8 into bit 7.
- R13: Codes 12 through 15 return 0x0000 regardless of A and B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand word |
| op_b | input | 16 | Second operand word; bits [3:0] give the shift amount |
| func_sel | input | 4 | Function code, 0 to 15 |
| result | output | 16 | Result word for the selected function |

## Verification
The block holds no state, so any fault shows up in the result word for the same operands and code. It never depends on an earlier vector. A fault in the shared adder's invert or carry-in control corrupts subtract and set-less-than together. A lane-boundary fault leaks a carry or borrow into bit 8, and that is visible only with operands whose low-lane sum overflows. A fault in one shifter stage shows only for shift amounts that have the matching bit of B[3:0] set. The directed vectors therefore pin each stage, each lane edge and the zero-divisor lanes, and a broad swept set compares against an independent model.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   localparam int FN_BITS = 4;

   typedef enum logic [FN_BITS-1:0] {
      FN_ADD   = 4'd0,
      FN_SUB   = 4'd1,
      FN_SHL   = 4'd2,
      FN_SHR_L = 4'd3,
      FN_SHR_A = 4'd4,
      FN_LT_S  = 4'd5,
      FN_OR    = 4'd6,
      FN_AND   = 4'd7,
      FN_LMUL  = 4'd8,
      FN_LDIV  = 4'd9,
      FN_LADD  = 4'd10,
      FN_LSUB  = 4'd11
   } alu_fn_e;

endpackage

// File: rtl/alu16_lane_unit.sv
// One unsigned byte-wide lane: truncated multiply, restoring divide,
// wrapping add and subtract. No signal leaves the lane except its results.
module alu16_lane_unit #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   output logic [LANE_W-1:0] mul_o,
   output logic [LANE_W-1:0] div_o,
   output logic [LANE_W-1:0] add_o,
   output logic [LANE_W-1:0] sub_o
);

   if (LANE_W < 2) begin : g_bad_lane
      $error("alu16_lane_unit: LANE_W must be at least 2");
   end

   // Shift-and-add multiply; only the low LANE_W bits are ever formed.
   always_comb begin
      mul_o = '0;
      for (int i = 0; i < LANE_W; i++) begin
         if (lane_b[i]) begin
            mul_o = mul_o + (lane_a << i);
         end
      end
   end

   // Restoring division. A zero divisor makes every trial subtraction
   // succeed, so the quotient saturates to all ones by itself.
   logic [LANE_W:0]   part_rem;
   logic [LANE_W-1:0] quo;

   always_comb begin
      part_rem = '0;
      quo      = '0;
      for (int i = LANE_W - 1; i >= 0; i--) begin
         part_rem = {part_rem[LANE_W-1:0], lane_a[i]};
         if (part_rem >= {1'b0, lane_b}) begin
            part_rem = part_rem - {1'b0, lane_b};
            quo[i]   = 1'b1;
         end
      end
   end

   assign div_o = quo;
   assign add_o = lane_a + lane_b;
   assign sub_o = lane_a - lane_b;

endmodule

// File: rtl/alu16_addsub.sv
// Single shared adder for add, subtract and signed compare.
module alu16_addsub #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] add_a,
   input  logic [DATA_W-1:0] add_b,
   input  logic              sub_en,
   output logic [DATA_W-1:0] sum_o,
   output logic              lt_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W-1:0] cin_vec;

   assign b_eff   = add_b ^ {DATA_W{sub_en}};
   assign cin_vec = {{(DATA_W-1){1'b0}}, sub_en};
   assign sum_o   = add_a + b_eff + cin_vec;

   // Signs differ: the negative operand is the smaller one.
   // Signs agree: the difference cannot overflow, so its sign decides.
   assign lt_o = (add_a[MSB] ^ add_b[MSB]) ? add_a[MSB] : sum_o[MSB];

endmodule

// File: rtl/alu16_shifter.sv
// Logarithmic right shifter; left shifts reuse it through bit reversal.
module alu16_shifter #(
   parameter int DATA_W = 16,
   parameter int SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] sh_val,
   input  logic [SH_W-1:0]   sh_amt,
   input  logic              dir_left,
   input  logic              arith,
   output logic [DATA_W-1:0] sh_res
);

   if ((1 << SH_W) != DATA_W) begin : g_bad_width
      $error("alu16_shifter: DATA_W must equal 2**SH_W");
   end

   logic              fill;
   logic [DATA_W-1:0] stg [SH_W+1];

   assign fill = ~dir_left & arith & sh_val[DATA_W-1];

   for (genvar i = 0; i < DATA_W; i++) begin : g_in_rev
      assign stg[0][i] = dir_left ? sh_val[DATA_W-1-i] : sh_val[i];
   end

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stg[s+1] = sh_amt[s]
                      ? {{STEP{fill}}, stg[s][DATA_W-1:STEP]}
                      : stg[s];
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_out_rev
      assign sh_res[i] = dir_left ? stg[SH_W][DATA_W-1-i] : stg[SH_W][i];
   end

endmodule

// File: rtl/alu16_lanes.sv
module alu16_lanes
   import alu16_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0]  op_a,
   input  logic [DATA_W-1:0]  op_b,
   input  logic [FN_BITS-1:0] func_sel,
   output logic [DATA_W-1:0]  result
);

   localparam int NUM_LANES = DATA_W / LANE_W;
   localparam int SH_W      = $clog2(DATA_W);

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("alu16_lanes: DATA_W must be a multiple of LANE_W");
   end
   if (NUM_LANES < 2) begin : g_bad_count
      $error("alu16_lanes: at least two lanes are required");
   end

   // Scalar add / subtract / compare on one adder.
   logic              sub_en;
   logic [DATA_W-1:0] sum_w;
   logic              lt_w;

   assign sub_en = (func_sel == FN_SUB) || (func_sel == FN_LT_S);

   alu16_addsub #(.DATA_W(DATA_W)) u_addsub (
      .add_a  (op_a),
      .add_b  (op_b),
      .sub_en (sub_en),
      .sum_o  (sum_w),
      .lt_o   (lt_w)
   );

   // Shifts.
   logic [DATA_W-1:0] shift_w;

   alu16_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
      .sh_val   (op_a),
      .sh_amt   (op_b[SH_W-1:0]),
      .dir_left (func_sel == FN_SHL),
      .arith    (func_sel == FN_SHR_A),
      .sh_res   (shift_w)
   );

   // Packed lanes.
   logic [DATA_W-1:0] lmul_w;
   logic [DATA_W-1:0] ldiv_w;
   logic [DATA_W-1:0] ladd_w;
   logic [DATA_W-1:0] lsub_w;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      alu16_lane_unit #(.LANE_W(LANE_W)) u_lane (
         .lane_a (op_a[g*LANE_W +: LANE_W]),
         .lane_b (op_b[g*LANE_W +: LANE_W]),
         .mul_o  (lmul_w[g*LANE_W +: LANE_W]),
         .div_o  (ldiv_w[g*LANE_W +: LANE_W]),
         .add_o  (ladd_w[g*LANE_W +: LANE_W]),
         .sub_o  (lsub_w[g*LANE_W +: LANE_W])
      );
   end

   // Result select.
   always_comb begin
      case (func_sel)
         FN_ADD,
         FN_SUB:   result = sum_w;
         FN_SHL,
         FN_SHR_L,
         FN_SHR_A: result = shift_w;
         FN_LT_S:  result = {{(DATA_W-1){1'b0}}, lt_w};
         FN_OR:    result = op_a | op_b;
         FN_AND:   result = op_a & op_b;
         FN_LMUL:  result = lmul_w;
         FN_LDIV:  result = ldiv_w;
         FN_LADD:  result = ladd_w;
         FN_LSUB:  result = lsub_w;
         default:  result = '0;
      endcase
   end

endmodule

// File: rtl/alu16_lanes_chk.sv
module alu16_lanes_chk #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [3:0]        func_sel,
   input logic [DATA_W-1:0] result
);

   localparam int NUM_LANES = DATA_W / LANE_W;
   localparam int SH_W      = $clog2(DATA_W);

   logic [DATA_W-1:0] all_ones;
   logic [DATA_W-1:0] low_mask;
   logic [DATA_W-1:0] high_mask;
   logic [SH_W-1:0]   shamt;

   assign all_ones  = '1;
   assign shamt     = op_b[SH_W-1:0];
   assign low_mask  = ~(all_ones << shamt);
   assign high_mask = ~(all_ones >> shamt);

   always_comb begin
      if (func_sel == 4'd0) AST_ADD_INVERSE: assert (result - op_b == op_a);          // R1
      if (func_sel == 4'd1) AST_SUB_INVERSE: assert (result + op_b == op_a);          // R2
      if (func_sel == 4'd2) AST_SHL_LOW_CLEAR: assert ((result & low_mask) == '0);    // R3
      if (func_sel == 4'd3) AST_SHR_TOP_CLEAR: assert ((result & high_mask) == '0);   // R4
      if (func_sel == 4'd4) AST_SRA_TOP_SIGN: assert ((result & high_mask) ==
                                  (op_a[DATA_W-1] ? high_mask : '0));                 // R5
      if (func_sel == 4'd5) AST_SLT_BOOLEAN: assert (result[DATA_W-1:1] == '0);       // R6
      if (func_sel >= 4'd12) AST_UNUSED_ZERO: assert (result == '0);                  // R13
   end

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_chk
      logic [LANE_W-1:0]   la, lb, lr;
      logic [2*LANE_W-1:0] wa, wb, wq, wprod;

      assign la    = op_a[g*LANE_W +: LANE_W];
      assign lb    = op_b[g*LANE_W +: LANE_W];
      assign lr    = result[g*LANE_W +: LANE_W];
      assign wa    = {{LANE_W{1'b0}}, la};
      assign wb    = {{LANE_W{1'b0}}, lb};
      assign wq    = {{LANE_W{1'b0}}, lr};
      assign wprod = wq * wb;

      always_comb begin
         if (func_sel == 4'd9 && lb == '0) AST_LDIV_ZERO_SAT: assert (lr == '1);     // R10
         if (func_sel == 4'd9 && lb != '0) AST_LDIV_BOUND: assert (wprod <= wa &&
                                              (wa - wprod) < wb);                     // R9
         if (func_sel == 4'd10) AST_LADD_ISOLATED: assert (lr - lb == la);            // R11
         if (func_sel == 4'd11) AST_LSUB_ISOLATED: assert (lr + lb == la);            // R12
      end
   end

endmodule

bind alu16_lanes alu16_lanes_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
   .op_a     (op_a),
   .op_b     (op_b),
   .func_sel (func_sel),
   .result   (result)
);

// File: tb/alu16_lanes_tb_top.sv
`timescale 1ns/1ps
module alu16_lanes_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic [3:0]  func_sel = '0;
   logic [15:0] result;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   alu16_lanes dut_i (
      .op_a     (op_a),
      .op_b     (op_b),
      .func_sel (func_sel),
      .result   (result)
   );

   function automatic logic [7:0] byte_div(input logic [7:0] n, input logic [7:0] d);
      return (d == 8'd0) ? 8'hFF : n / d;
   endfunction

   // Independent model written from the requirement list.
   function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                         input logic [3:0] s);
      logic [15:0] r;
      case (s)
         4'd0:  r = a + b;
         4'd1:  r = a - b;
         4'd2:  r = a << b[3:0];
         4'd3:  r = a >> b[3:0];
         4'd4:  r = $signed(a) >>> b[3:0];
         4'd5:  r = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
         4'd6:  r = a | b;
         4'd7:  r = a & b;
         4'd8:  r = {8'(a[15:8] * b[15:8]), 8'(a[7:0] * b[7:0])};
         4'd9:  r = {byte_div(a[15:8], b[15:8]), byte_div(a[7:0], b[7:0])};
         4'd10: r = {8'(a[15:8] + b[15:8]), 8'(a[7:0] + b[7:0])};
         4'd11: r = {8'(a[15:8] - b[15:8]), 8'(a[7:0] - b[7:0])};
         default: r = 16'h0000;
      endcase
      return r;
   endfunction

   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [3:0] s,
                        input logic [15:0] exp, input string req);
      @(negedge clk);
      op_a = a;
      op_b = b;
      func_sel = s;
      @(posedge clk);
      #1;
      n_checks++;
      if (result !== exp) begin
         n_fails++;
         $display("FAIL %s: a=%h b=%h sel=%0d actual=%h expected=%h",
                  req, a, b, s, result, exp);
      end
   endtask

   task automatic t_reset_state();
      apply(16'h0000, 16'h0000, 4'd0, 16'h0000, "R1");
   endtask

   task automatic t_add_sub();
      apply(16'h1234, 16'h4321, 4'd0, 16'h5555, "R1");
      apply(16'hFFFF, 16'h0001, 4'd0, 16'h0000, "R1");
      apply(16'h0005, 16'h0007, 4'd1, 16'hFFFE, "R2");
      apply(16'h8000, 16'h0001, 4'd1, 16'h7FFF, "R2");
   endtask

   task automatic t_shifts();
      apply(16'h00F1, 16'h0004, 4'd2, 16'h0F10, "R3");
      apply(16'h8001, 16'hFFF3, 4'd2, 16'h0008, "R3");
      apply(16'h1234, 16'h0010, 4'd2, 16'h1234, "R3");
      apply(16'h8000, 16'h000F, 4'd3, 16'h0001, "R4");
      apply(16'hF0F0, 16'h0004, 4'd3, 16'h0F0F, "R4");
      apply(16'h8000, 16'h000F, 4'd4, 16'hFFFF, "R5");
      apply(16'hF0F0, 16'h0004, 4'd4, 16'hFF0F, "R5");
      apply(16'h7000, 16'h0004, 4'd4, 16'h0700, "R5");
   endtask

   task automatic t_slt();
      apply(16'hFFFF, 16'h0001, 4'd5, 16'h0001, "R6");
      apply(16'h0001, 16'hFFFF, 4'd5, 16'h0000, "R6");
      apply(16'h0005, 16'h0005, 4'd5, 16'h0000, "R6");
      apply(16'h8000, 16'h7FFF, 4'd5, 16'h0001, "R6");
   endtask

   task automatic t_logic();
      apply(16'h0F0F, 16'h00FF, 4'd6, 16'h0FFF, "R7");
      apply(16'h0F0F, 16'h00FF, 4'd7, 16'h000F, "R7");
   endtask

   task automatic t_lane_mul();
      apply(16'h0310, 16'h0420, 4'd8, 16'h0C00, "R8");
      apply(16'h0F0F, 16'h1111, 4'd8, 16'hFFFF, "R8");
      apply(16'hFF02, 16'hFF03, 4'd8, 16'h0106, "R8");
   endtask

   task automatic t_lane_div();
      apply(16'h6407, 16'h0A02, 4'd9, 16'h0A03, "R9");
      apply(16'hFF80, 16'h0301, 4'd9, 16'h5580, "R9");
   endtask

   task automatic t_div_zero();
      apply(16'h1234, 16'h0005, 4'd9, 16'hFF0A, "R10");
      apply(16'h4000, 16'h0000, 4'd9, 16'hFFFF, "R10");
      apply(16'h0000, 16'h0100, 4'd9, 16'h00FF, "R10");
   endtask

   task automatic t_lane_add_sub();
      apply(16'h80FF, 16'h8001, 4'd10, 16'h0000, "R11");
      apply(16'h1234, 16'h0101, 4'd10, 16'h1335, "R11");
      apply(16'h0000, 16'h0001, 4'd11, 16'h00FF, "R12");
      apply(16'h0100, 16'h0001, 4'd11, 16'h01FF, "R12");
   endtask

   task automatic t_unused_codes();
      for (int s = 12; s < 16; s++) begin
         apply(16'hFFFF, 16'hFFFF, 4'(s), 16'h0000, "R13");
      end
   endtask

   task automatic t_sweep();
      logic [15:0] lfsr_a = 16'hACE1;
      logic [15:0] lfsr_b = 16'h1D2B;
      string tags [16] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R7",
                           "R8", "R9", "R11", "R12", "R13", "R13", "R13", "R13"};
      for (int k = 0; k < 40; k++) begin
         lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
         lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
         for (int s = 0; s < 16; s++) begin
            apply(lfsr_a, lfsr_b, 4'(s), model(lfsr_a, lfsr_b, 4'(s)), tags[s]);
         end
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_add_sub();
      t_shifts();
      t_slt();
      t_logic();
      t_lane_mul();
      t_lane_div();
      t_div_zero();
      t_lane_add_sub();
      t_unused_codes();
      t_sweep();
      finish_run();
   end

   initial begin
      #100000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

endmodule